// File: doc/BRIEF.md
# UART Receive Queue with Idle Ageing

This block is the receive-side buffer of a serial port. A receiver front end hands it one character at a time, or signals a line-break event, and the block keeps the entries in a 32-deep first-in first-out store. The block also keeps the flags that software and the interrupt logic use:
- a threshold-driven ready flag;
- a data-present flag and an empty flag;
- sticky flags for overrun, break detection and ageing.

A register-read strobe from the bus decoder removes the oldest entry. The popped entry then appears on the read-data output with a valid marker.

The ageing counter covers characters that stay below the trigger level. It counts while the store holds data and the ready flag is low. It starts again from zero on every push or pop. When it reaches the programmed number of cycles, which by default is the time of eight 10-bit characters at the baud divisor, it sets the sticky ageing flag.

A synchronous soft clear empties the store and returns every flag to its idle state.

Top module: `rx_fifo_ager`

## Requirements
- R1: `canAccept` is high exactly while fewer than DEPTH (32) entries are stored, and a push accepted then increases the stored count by one.
- R2: A push (character or break) that arrives while the store is full is dropped and sets the sticky `overrunFlag`. The stored entries are unchanged.
- R3: An entry written into the last free slot is stored with its overrun tag (bit DATA_W) and its error tag (bit DATA_W+3) set.
- R4: After every push, `rxReady` is set when the stored count is at or above `trigLevel`.
- R5: After a pop without a push, `rxReady` clears when the remaining count is below `trigLevel`. Otherwise it keeps its value.
- R6: A push sets `dataReady` and clears `rxEmpty`. A pop that leaves zero entries clears `dataReady` and sets `rxEmpty`. The two flags are always complementary.
- R7: A pop of a non-empty store puts the entry on `popWord` with the valid marker at bit DATA_W+4, one clock after the strobe. A pop of an empty store gives all zeros and changes no flag.
- R8: The ageing counter runs only while `rxReady` is low and data is stored. Every push or pop restarts it from zero.
- R9: `ageFlag` sets AGE_CYCLES clocks after the last push or pop, if the counter has run without a break. It then stays set until a soft clear.
- R10: A push with `pushBreak` high stores an entry with char bits zero and the break (bit DATA_W+1), framing (bit DATA_W+2) and error tags set. `pushData` is ignored for that push. The push sets the sticky `breakFlag`.
- R11: Reset and `softClr` leave zero entries, `rxEmpty` set, `rxReady`, `dataReady` and all sticky flags clear, and `popWord` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softClr | input | 1 | Synchronous clear of store, flags and timer |
| trigLevel | input | $clog2(DEPTH)+1 | Ready trigger level |
| pushValid | input | 1 | Front end presents a received character |
| pushBreak | input | 1 | Front end reports a line-break event |
| pushData | input | DATA_W | Received character |
| canAccept | output | 1 | Store has a free slot |
| popStrobe | input | 1 | Read strobe that removes the oldest entry |
| popWord | output | DATA_W+5 | Popped entry: valid, error, framing, break, overrun, char |
| rxReady | output | 1 | Fill level has reached the trigger |
| dataReady | output | 1 | At least one entry is stored |
| rxEmpty | output | 1 | Store is empty |
| overrunFlag | output | 1 | Sticky: a push was dropped |
| breakFlag | output | 1 | Sticky: a line break was received |
| ageFlag | output | 1 | Sticky: data sat idle below the trigger |

## Verification
Every flag and `popWord` is a register that the same clock edge updates when it samples the push or pop strobe. The bench therefore drives each strobe for one edge, from a falling edge to the next falling edge, and reads the results at that next falling edge.

The ageing flag is due exactly AGE_CYCLES edges after the restarting edge. The bench counts that many falling edges and checks that the flag is still clear one edge before and set on the edge itself.

The trigger-level sweep keeps a running count and ready model in the bench. This gives each push and pop its own expected value.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Strobes from control to the storage datapath
  typedef struct packed {
    logic wr;      // write entry at tail
    logic rd;      // pop head onto popWord with valid marker
    logic rdNull;  // pop of an empty store: popWord goes to zero
    logic clr;     // soft clear
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int ENT_W = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxqStrobe_t                   strb,
  input  logic [ENT_W-1:0]             wrWord,
  output logic [$clog2(DEPTH):0]       level,
  output logic [ENT_W:0]               popWord
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strb.wr) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      popWord <= '0;
    end else if (strb.clr) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      popWord <= '0;
    end else begin
      if (strb.wr) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strb.rd) begin
        rdPtr   <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
        popWord <= {1'b1, mem[rdPtr]};
      end else if (strb.rdNull) begin
        popWord <= '0;
      end
      level <= level + CNT_W'(strb.wr) - CNT_W'(strb.rd);
    end
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 32,
  parameter int AGE_CYCLES = 1280
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      softClr,
  input  logic [$clog2(DEPTH):0]    trigLevel,
  input  logic                      pushValid,
  input  logic                      pushBreak,
  input  logic [DATA_W-1:0]         pushData,
  input  logic                      popStrobe,
  input  logic [$clog2(DEPTH):0]    level,
  output rxqStrobe_t                strb,
  output logic [DATA_W+3:0]         wrWord,
  output logic                      canAccept,
  output logic                      rxReady,
  output logic                      dataReady,
  output logic                      rxEmpty,
  output logic                      overrunFlag,
  output logic                      breakFlag,
  output logic                      ageFlag
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int AGE_W = $clog2(AGE_CYCLES + 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST_LVL = CNT_W'(DEPTH - 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(AGE_CYCLES - 1);
  localparam logic [AGE_W-1:0] AGE_DONE = AGE_W'(AGE_CYCLES);

  logic pushEv, full, doWr, doRd, lastSlot, nextGeTrig;
  logic [CNT_W-1:0] nextLevel;
  logic [AGE_W-1:0] ageCnt;
  logic ageRun;

  always_comb begin
    pushEv     = pushValid | pushBreak;
    full       = (level == FULL_LVL);
    lastSlot   = (level == LAST_LVL);
    doWr       = pushEv & ~full & ~softClr;
    doRd       = popStrobe & (level != '0) & ~softClr;
    strb.wr     = doWr;
    strb.rd     = doRd;
    strb.rdNull = popStrobe & (level == '0) & ~softClr;
    strb.clr    = softClr;
    nextLevel  = level + CNT_W'(doWr) - CNT_W'(doRd);
    nextGeTrig = (nextLevel >= trigLevel);
    // tags: error, framing, break, overrun, then char
    wrWord = {pushBreak | lastSlot, pushBreak, pushBreak, lastSlot,
              pushBreak ? '0 : pushData};
    canAccept = ~full;
    ageRun    = ~rxReady & dataReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReady     <= 1'b0;
      dataReady   <= 1'b0;
      rxEmpty     <= 1'b1;
      overrunFlag <= 1'b0;
      breakFlag   <= 1'b0;
      ageFlag     <= 1'b0;
      ageCnt      <= '0;
    end else if (softClr) begin
      rxReady     <= 1'b0;
      dataReady   <= 1'b0;
      rxEmpty     <= 1'b1;
      overrunFlag <= 1'b0;
      breakFlag   <= 1'b0;
      ageFlag     <= 1'b0;
      ageCnt      <= '0;
    end else begin
      if (pushEv && doRd)   rxReady <= nextGeTrig;
      else if (pushEv)      rxReady <= rxReady | nextGeTrig;
      else if (doRd)        rxReady <= rxReady & nextGeTrig;

      if (pushEv) begin
        dataReady <= 1'b1;
        rxEmpty   <= 1'b0;
      end else if (doRd && nextLevel == '0) begin
        dataReady <= 1'b0;
        rxEmpty   <= 1'b1;
      end

      if (pushEv && full) overrunFlag <= 1'b1;
      if (pushBreak)      breakFlag   <= 1'b1;

      if (pushEv || popStrobe || !ageRun) begin
        ageCnt <= '0;
      end else if (ageCnt != AGE_DONE) begin
        ageCnt <= ageCnt + 1'b1;
        if (ageCnt == AGE_LAST) ageFlag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_fifo_ager.sv
module rx_fifo_ager
  import rxq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 32,
  parameter int BAUD_DIV   = 16,
  parameter int AGE_CYCLES = 8 * 10 * BAUD_DIV
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      softClr,
  input  logic [$clog2(DEPTH):0]    trigLevel,
  input  logic                      pushValid,
  input  logic                      pushBreak,
  input  logic [DATA_W-1:0]         pushData,
  output logic                      canAccept,
  input  logic                      popStrobe,
  output logic [DATA_W+4:0]         popWord,
  output logic                      rxReady,
  output logic                      dataReady,
  output logic                      rxEmpty,
  output logic                      overrunFlag,
  output logic                      breakFlag,
  output logic                      ageFlag
);
  localparam int ENT_W = DATA_W + 4;

  rxqStrobe_t                strb;
  logic [ENT_W-1:0]          wrWord;
  logic [$clog2(DEPTH):0]    level;

  rxq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AGE_CYCLES(AGE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .softClr(softClr), .trigLevel(trigLevel),
    .pushValid(pushValid), .pushBreak(pushBreak), .pushData(pushData),
    .popStrobe(popStrobe), .level(level), .strb(strb), .wrWord(wrWord),
    .canAccept(canAccept), .rxReady(rxReady), .dataReady(dataReady),
    .rxEmpty(rxEmpty), .overrunFlag(overrunFlag), .breakFlag(breakFlag),
    .ageFlag(ageFlag)
  );

  rxq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrWord(wrWord),
    .level(level), .popWord(popWord)
  );
endmodule

// File: rtl/rx_fifo_ager_chk.sv
module rx_fifo_ager_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              softClr,
  input logic              pushValid,
  input logic              pushBreak,
  input logic              popStrobe,
  input logic              canAccept,
  input logic [DATA_W+4:0] popWord,
  input logic              rxReady,
  input logic              dataReady,
  input logic              rxEmpty,
  input logic              overrunFlag,
  input logic              breakFlag,
  input logic              ageFlag
);
  AST_FULL_PUSH_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !canAccept && !softClr) |=> overrunFlag); // R1
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && !softClr) |=> overrunFlag); // R2
  AST_EMPTY_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    dataReady != rxEmpty); // R6
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && rxEmpty && !pushValid && !pushBreak && !softClr) |=> (popWord == '0 && rxEmpty)); // R7
  AST_AGE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ageFlag) |-> ($past(!rxReady) && $past(dataReady))); // R8
  AST_AGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ageFlag && !softClr) |=> ageFlag); // R9
  AST_BREAK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (pushBreak && !softClr) |=> breakFlag); // R10
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    softClr |=> (rxEmpty && !rxReady && !overrunFlag && !breakFlag && !ageFlag)); // R11
endmodule

bind rx_fifo_ager rx_fifo_ager_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rx_fifo_ager_tb.sv
module rx_fifo_ager_tb;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 32;
  localparam int AGE    = 80;
  localparam int LVL_W  = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softClr = 1'b0;
  logic [LVL_W-1:0] trigLevel = '0;
  logic pushValid = 1'b0, pushBreak = 1'b0, popStrobe = 1'b0;
  logic [DATA_W-1:0] pushData = '0;
  logic canAccept, rxReady, dataReady, rxEmpty, overrunFlag, breakFlag, ageFlag;
  logic [DATA_W+4:0] popWord;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  rx_fifo_ager #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BAUD_DIV(1)) u_dut (
    .clk(clk), .rstN(rstN), .softClr(softClr), .trigLevel(trigLevel),
    .pushValid(pushValid), .pushBreak(pushBreak), .pushData(pushData),
    .canAccept(canAccept), .popStrobe(popStrobe), .popWord(popWord),
    .rxReady(rxReady), .dataReady(dataReady), .rxEmpty(rxEmpty),
    .overrunFlag(overrunFlag), .breakFlag(breakFlag), .ageFlag(ageFlag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic push(input logic [DATA_W-1:0] d, input logic brk);
    pushData = d; pushValid = ~brk; pushBreak = brk;
    @(negedge clk);
    pushValid = 1'b0; pushBreak = 1'b0;
  endtask

  task automatic pop();
    popStrobe = 1'b1;
    @(negedge clk);
    popStrobe = 1'b0;
  endtask

  task automatic clear();
    softClr = 1'b1;
    @(negedge clk);
    softClr = 1'b0;
  endtask

  function automatic int mkWord(int err, int frm, int brk, int ovr, int d);
    return (1 << 12) | (err << 11) | (frm << 10) | (brk << 9) | (ovr << 8) | d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int trigs [6] = '{0, 1, 7, 16, 31, 32};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset rxEmpty", rxEmpty, 1);
    chk("R11 reset rxReady", rxReady, 0);
    chk("R11 reset dataReady", dataReady, 0);
    chk("R11 reset popWord", popWord, 0);
    chk("R1 reset canAccept", canAccept, 1);

    foreach (trigs[t]) begin
      int lvl = 0;
      int rdy = 0;
      clear();
      trigLevel = LVL_W'(trigs[t]);
      for (int i = 0; i < DEPTH; i++) begin
        push(DATA_W'(i * 7 + trigs[t]), 1'b0);
        lvl++;
        if (lvl >= trigs[t]) rdy = 1;
        chk("R4 ready after push", rxReady, rdy);
        chk("R6 dataReady after push", dataReady, 1);
        chk("R1 canAccept", canAccept, (lvl < DEPTH) ? 1 : 0);
      end
      push(8'hAA, 1'b0);
      chk("R2 overrun on full push", overrunFlag, 1);
      for (int i = 0; i < DEPTH; i++) begin
        pop();
        lvl--;
        chk("R3 R7 popped word", popWord,
            mkWord(i == DEPTH-1, 0, 0, i == DEPTH-1, (i * 7 + trigs[t]) & 8'hFF));
        if (lvl < trigs[t]) rdy = 0;
        chk("R5 ready after pop", rxReady, rdy);
        chk("R6 empty after pop", rxEmpty, (lvl == 0) ? 1 : 0);
      end
      pop();
      chk("R7 empty pop word", popWord, 0);
      chk("R7 empty pop ready unchanged", rxReady, rdy);
      chk("R2 overrun sticky", overrunFlag, 1);
    end

    // R9 ageing expiry timing
    clear();
    trigLevel = 4;
    push(8'h11, 1'b0);
    push(8'h22, 1'b0);
    repeat (AGE - 1) @(negedge clk);
    chk("R9 age not yet", ageFlag, 0);
    @(negedge clk);
    chk("R9 age fires", ageFlag, 1);
    repeat (5) @(negedge clk);
    chk("R9 age sticky", ageFlag, 1);

    // R8 no ageing while ready is set
    clear();
    trigLevel = 1;
    push(8'h33, 1'b0);
    repeat (AGE + 20) @(negedge clk);
    chk("R8 no age while ready", ageFlag, 0);

    // R8 no ageing while empty
    clear();
    trigLevel = 4;
    repeat (AGE + 20) @(negedge clk);
    chk("R8 no age while empty", ageFlag, 0);

    // R8 restart on push and on pop
    clear();
    push(8'h44, 1'b0);
    repeat (50) @(negedge clk);
    push(8'h55, 1'b0);
    repeat (50) @(negedge clk);
    chk("R8 push restarts age", ageFlag, 0);
    pop();
    repeat (AGE - 1) @(negedge clk);
    chk("R8 pop restarts age", ageFlag, 0);
    @(negedge clk);
    chk("R9 age after pop restart", ageFlag, 1);

    // R10 break insertion
    clear();
    trigLevel = 1;
    push(8'h5A, 1'b1);
    chk("R10 breakFlag", breakFlag, 1);
    chk("R10 ready on break push", rxReady, 1);
    pop();
    chk("R10 break word", popWord, mkWord(1, 1, 1, 0, 0));

    // R11 soft clear after activity
    push(8'h66, 1'b0);
    push(8'h77, 1'b1);
    clear();
    chk("R11 clear rxEmpty", rxEmpty, 1);
    chk("R11 clear rxReady", rxReady, 0);
    chk("R11 clear dataReady", dataReady, 0);
    chk("R11 clear breakFlag", breakFlag, 0);
    chk("R11 clear popWord", popWord, 0);
    pop();
    chk("R11 store emptied", popWord, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule